// File: doc/BRIEF.md
# Typed Flit Packetizer

This block sits between a data producer and a network switch. Each accepted word arrives with a 2-bit type code, a destination port and a 4-bit integer-length field. The integer-length field marks where the fixed point sits in the data. The type code fixes how many payload bytes are kept.

The block frames the word into a packet and queues the whole packet in a small FIFO. It then sends the packet out one 8-bit flit per clock over a valid/ready link. Each packet is an 8-bit header, then the kept payload bytes, then a constant 0xFF tail.

Three lengths are possible, and the type code picks one at run time. Type 00 carries a 56-bit coefficient and gives 9 flits. Types 01 and 10 carry 48-bit image samples and give 8 flits. Type 11 carries an 8-bit result and gives 3 flits.

Top module: `flit_packetizer`

## Requirements
- R1: While reset is high and in the first cycle after it, `flit_valid` is 0 and `in_ready` is 1.
- R2: The first flit of every packet is the header: bits [7:6] are the destination port, bits [5:4] are the type code, and bits [3:0] are the integer-length field.
- R3: Type code 00 keeps 7 payload bytes, so the packet is 9 flits long.
- R4: Type codes 01 and 10 keep 6 payload bytes each, so each packet is 8 flits long.
- R5: Type code 11 keeps 1 payload byte, so the packet is 3 flits long.
- R6: Payload flits follow the header with the least significant data byte first. Data bits above the width that the type code selects do not reach the output.
- R7: The last flit of every packet is 0xFF, and `flit_last` is high on that flit and on no other.
- R8: While `flit_valid` is high and `flit_ready` is low, `flit_valid` and `flit_data` hold their values into the next cycle.
- R9: `in_ready` is low exactly when DEPTH packets are queued. A word offered while `in_ready` is low is dropped and yields no packet.
- R10: Packets leave in the order they were accepted. `flit_valid` is high whenever at least one packet is queued, so flits flow back to back while `flit_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Space for one more packet |
| in_data | input | 56 | Data word; only the low bytes selected by the type code are used |
| in_type | input | 2 | Type code: 00 coefficient, 01 original sample, 10 compared sample, 11 result |
| in_port | input | 2 | Destination port |
| in_ilen | input | 4 | Integer-length (fixed-point position) field |
| flit_valid | output | 1 | Output flit valid |
| flit_ready | input | 1 | Switch accepts the flit |
| flit_data | output | 8 | Output flit |
| flit_last | output | 1 | Flit is the packet tail |

## Verification
The bench sends each of the four type codes with distinctive byte patterns. It puts garbage in the data bits above each type's width, so a wrong length decode or a missing mask shows up as a byte or count mismatch. A phase with the output stalled fills the queue and then keeps offering a word. This separates correct back-pressure from silent over-acceptance, and the stall also exercises the output hold. A long run with random types, data and `flit_ready` then checks ordering and gap-free flow against a queue-based reference model on every clock.

// File: rtl/pna_pkg.sv
package pna_pkg;
    localparam int FLIT_W        = 8;
    localparam int PORT_W        = 2;
    localparam int TYPE_W        = 2;
    localparam int ILEN_W        = 4;
    localparam int MAX_PAY_FLITS = 7;
    localparam int MAX_FLITS     = MAX_PAY_FLITS + 2;
    localparam int PAY_W         = MAX_PAY_FLITS * FLIT_W;
    localparam int CNT_W         = $clog2(MAX_FLITS + 1);
    localparam logic [FLIT_W-1:0] TAIL_FLIT = 8'hFF;

    typedef enum logic [TYPE_W-1:0] {
        TY_COEF = 2'b00,
        TY_ORIG = 2'b01,
        TY_CMP  = 2'b10,
        TY_RES  = 2'b11
    } ptype_e;

    typedef struct packed {
        logic [CNT_W-1:0]                  nflits;
        logic [MAX_FLITS-1:0][FLIT_W-1:0]  flits;
    } packet_t;

    function automatic logic [CNT_W-1:0] payload_flits(ptype_e t);
        case (t)
            TY_COEF: return CNT_W'(7);
            TY_ORIG: return CNT_W'(6);
            TY_CMP:  return CNT_W'(6);
            default: return CNT_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/pna_type_decode.sv
module pna_type_decode
    import pna_pkg::*;
(
    input  ptype_e           ty,
    output logic [CNT_W-1:0] pay_flits,
    output logic [CNT_W-1:0] total_flits
);
    always_comb begin
        pay_flits   = payload_flits(ty);
        total_flits = pay_flits + CNT_W'(2);
    end
endmodule

// File: rtl/pna_framer.sv
module pna_framer
    import pna_pkg::*;
(
    input  logic [PAY_W-1:0]  data,
    input  ptype_e            ty,
    input  logic [PORT_W-1:0] port,
    input  logic [ILEN_W-1:0] ilen,
    input  logic [CNT_W-1:0]  pay_flits,
    input  logic [CNT_W-1:0]  total_flits,
    output packet_t           pkt
);
    always_comb begin
        pkt          = '0;
        pkt.nflits   = total_flits;
        pkt.flits[0] = {port, ty, ilen};
        for (int i = 0; i < MAX_PAY_FLITS; i++) begin
            if (CNT_W'(i) < pay_flits)
                pkt.flits[i+1] = data[i*FLIT_W +: FLIT_W];
        end
        for (int i = 1; i < MAX_FLITS; i++) begin
            if (CNT_W'(i) == pay_flits + CNT_W'(1))
                pkt.flits[i] = TAIL_FLIT;
        end
    end
endmodule

// File: rtl/pna_fifo.sv
module pna_fifo #(
    parameter int  DEPTH = 4,
    parameter type T     = logic [7:0]
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  T     wdata,
    input  logic pop,
    output T     rdata,
    output logic full,
    output logic empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    T                mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   cnt;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign rdata = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) push |-> !full);  // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);  // R10
    AST_COUNT_BOUND:  assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH)); // R9
endmodule

// File: rtl/pna_serializer.sv
module pna_serializer
    import pna_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  packet_t           head,
    input  logic              head_valid,
    output logic              pop,
    output logic              flit_valid,
    input  logic              flit_ready,
    output logic [FLIT_W-1:0] flit_data,
    output logic              flit_last
);
    logic [CNT_W-1:0] idx;
    logic             fire;

    assign flit_valid = head_valid;
    assign flit_data  = head.flits[idx];
    assign flit_last  = head_valid && (idx == head.nflits - CNT_W'(1));
    assign fire       = flit_valid && flit_ready;
    assign pop        = fire && flit_last;

    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (pop)  idx <= '0;
        else if (fire) idx <= idx + CNT_W'(1);
    end

    AST_HOLD_FLIT:   assert property (@(posedge clk) disable iff (rst)
                         flit_valid && !flit_ready |=> flit_valid && $stable(flit_data)); // R8
    AST_TAIL_ON_LAST: assert property (@(posedge clk) disable iff (rst)
                         flit_last |-> flit_data == TAIL_FLIT);                           // R7
    AST_IDX_RESTART: assert property (@(posedge clk) disable iff (rst)
                         pop |=> idx == '0);                                              // R10
endmodule

// File: rtl/flit_packetizer.sv
module flit_packetizer
    import pna_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PAY_W-1:0]  in_data,
    input  logic [TYPE_W-1:0] in_type,
    input  logic [PORT_W-1:0] in_port,
    input  logic [ILEN_W-1:0] in_ilen,
    output logic              flit_valid,
    input  logic              flit_ready,
    output logic [FLIT_W-1:0] flit_data,
    output logic              flit_last
);
    logic [CNT_W-1:0] pay_flits, total_flits;
    packet_t          new_pkt, head_pkt;
    logic             full, empty, push, pop;
    ptype_e           ty;

    assign ty       = ptype_e'(in_type);
    assign in_ready = !full;
    assign push     = in_valid && in_ready;

    pna_type_decode u_dec (
        .ty(ty), .pay_flits(pay_flits), .total_flits(total_flits)
    );

    pna_framer u_frm (
        .data(in_data), .ty(ty), .port(in_port), .ilen(in_ilen),
        .pay_flits(pay_flits), .total_flits(total_flits), .pkt(new_pkt)
    );

    pna_fifo #(.DEPTH(DEPTH), .T(packet_t)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(new_pkt),
        .pop(pop), .rdata(head_pkt), .full(full), .empty(empty)
    );

    pna_serializer u_ser (
        .clk(clk), .rst(rst), .head(head_pkt), .head_valid(!empty),
        .pop(pop), .flit_valid(flit_valid), .flit_ready(flit_ready),
        .flit_data(flit_data), .flit_last(flit_last)
    );

    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
                            !in_ready && !flit_ready |=> !in_ready);  // R9
endmodule

// File: tb/test_flit_packetizer.sv
module test_flit_packetizer;
    localparam int DEPTH = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0;
    logic        in_ready;
    logic [55:0] in_data = '0;
    logic [1:0]  in_type = '0;
    logic [1:0]  in_port = '0;
    logic [3:0]  in_ilen = '0;
    logic        flit_valid;
    logic        flit_ready = 0;
    logic [7:0]  flit_data;
    logic        flit_last;

    always #10 clk = ~clk;

    flit_packetizer #(.DEPTH(DEPTH)) i_flit_packetizer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_type(in_type), .in_port(in_port), .in_ilen(in_ilen),
        .flit_valid(flit_valid), .flit_ready(flit_ready),
        .flit_data(flit_data), .flit_last(flit_last)
    );

    int    errors = 0, checks = 0, cyc = 0;
    int    exp_q[$];
    int    len_q[$];
    string tag_q[$];
    int    pkts = 0, dut_cnt = 0;
    bit    prev_stall = 0, rnd_ready = 0, last_acc = 0;
    logic [7:0] prev_data = '0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int npay(logic [1:0] t);
        return (t == 2'b00) ? 7 : (t == 2'b11) ? 1 : 6;
    endfunction

    task automatic tick();
        int    e;
        string req;
        bit    fire, acc;
        if (rnd_ready) flit_ready = $urandom_range(0, 1);
        check(in_ready == (pkts < DEPTH), "R9", "in_ready", in_ready, pkts < DEPTH);
        check(flit_valid == (pkts > 0), "R10", "flit_valid", flit_valid, pkts > 0);
        if (prev_stall) check(flit_data == prev_data, "R8", "held flit", flit_data, prev_data);
        if (flit_valid && exp_q.size() > 0) begin
            e   = exp_q[0];
            req = (dut_cnt == 0) ? "R2" : (e[8] ? "R7" : "R6");
            check(flit_data == e[7:0], req, "flit_data", flit_data, e[7:0]);
            check(flit_last == e[8], "R7", "flit_last", flit_last, e[8]);
        end
        fire = flit_valid && flit_ready;
        acc  = in_valid && (pkts < DEPTH);
        prev_stall = flit_valid && !flit_ready;
        prev_data  = flit_data;
        if (fire) begin
            dut_cnt++;
            if (flit_last && len_q.size() > 0)
                check(dut_cnt == len_q[0], tag_q[0], "packet length", dut_cnt, len_q[0]);
            if (flit_last) dut_cnt = 0;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                if (e[8]) begin
                    pkts--;
                    void'(len_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
        if (acc) begin
            int n = npay(in_type);
            exp_q.push_back({24'd0, in_port, in_type, in_ilen});
            for (int i = 0; i < n; i++) exp_q.push_back(int'(in_data[i*8 +: 8]));
            exp_q.push_back(32'h1FF);
            len_q.push_back(n + 2);
            tag_q.push_back(in_type == 2'b00 ? "R3" : (in_type == 2'b11 ? "R5" : "R4"));
            pkts++;
        end
        last_acc = acc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(logic [1:0] t, logic [1:0] p, logic [3:0] il, logic [55:0] d);
        in_valid = 1; in_type = t; in_port = p; in_ilen = il; in_data = d;
        last_acc = 0;
        while (!last_acc) tick();
        in_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(flit_valid == 0, "R1", "flit_valid in reset", flit_valid, 0);
        check(in_ready == 1, "R1", "in_ready in reset", in_ready, 1);
        rst = 0;
        check(flit_valid == 0, "R1", "flit_valid after reset", flit_valid, 0);

        // Each type with ready high; garbage above the used width (R6).
        flit_ready = 1;
        send(2'b00, 2'd1, 4'd3, 56'h07_0605_0403_0201);
        send(2'b01, 2'd2, 4'd9, 56'hEE_1615_1413_1211);
        send(2'b10, 2'd3, 4'd0, 56'hDD_2625_2423_2221);
        send(2'b11, 2'd0, 4'd15, 56'hAB_CDEF_0123_4542);
        idle(30);

        // Stall output, fill the FIFO, offer while full (R9, R8).
        flit_ready = 0;
        for (int k = 0; k < DEPTH; k++)
            send(2'(k), 2'(k), 4'(k + 5), {8'h5A, 48'h0, 8'(k * 17)});
        in_valid = 1; in_type = 2'b11; in_data = 56'h99; in_port = 2'd3;
        idle(6);
        in_valid = 0;
        flit_ready = 1;
        idle(45);

        // Random types, data and ready (R10).
        rnd_ready = 1;
        for (int k = 0; k < 40; k++)
            send(2'($urandom), 2'($urandom), 4'($urandom),
                 {24'($urandom), 32'($urandom)});
        rnd_ready = 0;
        flit_ready = 1;
        idle(100);
        check(exp_q.size() == 0, "R10", "flits left over", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule